// File: doc/BRIEF.md
# Byte Lane Select Generator

This block drives the two active-low byte-lane strobes of a 16-bit external memory bus. For an ordinary access it works out which byte lanes carry valid data. It bases this on the port width of the selected bank, the number of bytes in the transfer and the low address bits. Lane 0 is the most significant byte, data bits 0 to 7 in big-endian numbering. Lane 1 covers data bits 8 to 15. The strobes are registered and change one bus clock after their inputs are sampled.

Two overrides take precedence over the decode. While the memory sequencer runs a refresh-timer cycle, the strobes copy the lane bits of the refresh pattern and ignore width, count and address. A bus-monitor exception outranks everything, refresh included. From the next clock after the exception, every lane is driven inactive, whatever the exception pattern requests. The lanes stay inactive until a new access begins. This keeps a stray write from reaching external RAM after a timed-out access.

Top module: `lane_sel_gen`

## Requirements
- R1: While `rst` is sampled high, and on the first clock after it, `lane_n` is all ones (every lane inactive).
- R2: `lane_n` is registered: each value reflects the inputs sampled at the previous rising edge of `clk`. Bit 0 is the upper byte lane (data bits 0..7) and bit 1 is the lower byte lane (data bits 8..15). A 0 means asserted. `port_size` encodes log2 of the port width in bytes: 0 is an 8-bit port and 1 is a 16-bit port.
- R3: For a 16-bit port, a transfer of 2 or more bytes at an even address (`addr_lo`=0) gives `lane_n`=2'b00.
- R4: For a 16-bit port, a 1-byte transfer gives `lane_n`=2'b10 at an even address and 2'b01 at an odd address.
- R5: A transfer that would run past the port edge is clipped. On a 16-bit port, 2 bytes at an odd address gives `lane_n`=2'b01.
- R6: For an 8-bit port (`port_size`=0) with a nonzero count, `lane_n`=2'b10 for any address and count. Lane 1 is never asserted for such a port outside refresh.
- R7: With no refresh, a cycle that has `cyc_valid`=0 or `byte_cnt`=0 gives `lane_n`=2'b11.
- R8: With `refresh`=1 and no exception in effect, `lane_n` is the inverse of `pat_lane`, regardless of `cyc_valid`, `port_size`, `byte_cnt` and `addr_lo`.
- R9: A cycle with `bus_exc`=1 gives `lane_n`=2'b11, even during refresh.
- R10: After `bus_exc`, `lane_n` stays 2'b11 on every later cycle until a cycle is sampled with `access_start`=1 and `bus_exc`=0. That cycle and the ones after it decode normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A normal data cycle is in progress |
| access_start | input | 1 | First cycle of a new access; ends an exception hold |
| port_size | input | 1 | log2 of the selected bank's port width in bytes |
| byte_cnt | input | 2 | Bytes in the transfer (0 means none) |
| addr_lo | input | 1 | Low address bit(s) of the access |
| refresh | input | 1 | Refresh-timer cycle in progress |
| pat_lane | input | 2 | Refresh pattern lane bits, 1 = assert the lane |
| bus_exc | input | 1 | Bus-monitor exception pulse |
| lane_n | output | 2 | Active-low byte-lane strobes, bit 0 = upper byte |

## Verification
The bound checker enforces the overrides on every clock:
- An exception always blanks the next output.
- The hold keeps the strobes blank until a new access starts.
- Refresh output mirrors the pattern.
- An 8-bit port never drives the low lane.
- Idle or zero-count cycles leave every lane inactive.

The address and size decode values for 16-bit ports are shown only by the bench's scenarios:
- both lanes at even addresses;
- single bytes at either address;
- clipping at an odd address.

The bench scenarios also cover reset and the exact cycle on which a new access releases the hold.

// File: rtl/lane_sel_pkg.sv
package lane_sel_pkg;

  // Source that decides the next strobe value.
  typedef enum logic [1:0] {
    SRC_IDLE    = 2'd0,
    SRC_DECODE  = 2'd1,
    SRC_PATTERN = 2'd2,
    SRC_BLOCKED = 2'd3
  } lane_src_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode #(
  parameter int LANES  = 2,
  parameter int PS_W   = 1,
  parameter int CNT_W  = 2,
  parameter int ADDR_W = 1
) (
  input  logic [PS_W-1:0]   port_size,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [ADDR_W-1:0] addr_lo,
  output logic [LANES-1:0]  lane_mask
);

  // Lane k is active when it lies inside [offset, offset+count) and inside the port.
  always_comb begin
    int width;
    int offset;
    int count;
    width = 1 << int'(port_size);
    if (width > LANES) width = LANES;
    offset = int'(addr_lo) & (width - 1);
    count  = int'(byte_cnt);
    for (int k = 0; k < LANES; k++) begin
      lane_mask[k] = (count != 0) && (k >= offset) && (k < offset + count) && (k < width);
    end
  end

endmodule

// File: rtl/lane_exc_hold.sv
module lane_exc_hold (
  input  logic clk,
  input  logic rst,
  input  logic bus_exc,
  input  logic access_start,
  output logic blocked,
  output logic hold_q
);

  // Blank this cycle if an exception arrives now, or an old one has not been released.
  assign blocked = bus_exc | (hold_q & ~access_start);

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= blocked;
  end

endmodule

// File: rtl/lane_mode_sel.sv
module lane_mode_sel
  import lane_sel_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic              cyc_valid,
  input  logic              refresh,
  input  logic              blocked,
  input  logic [LANES-1:0]  pat_lane,
  input  logic [LANES-1:0]  lane_mask,
  output lane_src_e         src,
  output logic [LANES-1:0]  next_n
);

  always_comb begin
    if (blocked)        src = SRC_BLOCKED;
    else if (refresh)   src = SRC_PATTERN;
    else if (cyc_valid) src = SRC_DECODE;
    else                src = SRC_IDLE;
  end

  always_comb begin
    case (src)
      SRC_PATTERN: next_n = ~pat_lane;
      SRC_DECODE:  next_n = ~lane_mask;
      default:     next_n = '1;
    endcase
  end

endmodule

// File: rtl/lane_sel_gen.sv
module lane_sel_gen #(
  parameter int LANES  = 2,
  parameter int LOG2L  = $clog2(LANES),
  parameter int PS_W   = (LOG2L < 1) ? 1 : $clog2(LOG2L + 1),
  parameter int CNT_W  = $clog2(LANES + 1),
  parameter int ADDR_W = (LOG2L < 1) ? 1 : LOG2L
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              access_start,
  input  logic [PS_W-1:0]   port_size,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              refresh,
  input  logic [LANES-1:0]  pat_lane,
  input  logic              bus_exc,
  output logic [LANES-1:0]  lane_n
);
  import lane_sel_pkg::*;

  logic [LANES-1:0] lane_mask;
  logic [LANES-1:0] next_n;
  logic             blocked;
  logic             hold_q;
  lane_src_e        src;

  lane_decode #(
    .LANES(LANES), .PS_W(PS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .port_size(port_size),
    .byte_cnt (byte_cnt),
    .addr_lo  (addr_lo),
    .lane_mask(lane_mask)
  );

  lane_exc_hold u_hold (
    .clk         (clk),
    .rst         (rst),
    .bus_exc     (bus_exc),
    .access_start(access_start),
    .blocked     (blocked),
    .hold_q      (hold_q)
  );

  lane_mode_sel #(.LANES(LANES)) u_sel (
    .cyc_valid(cyc_valid),
    .refresh  (refresh),
    .blocked  (blocked),
    .pat_lane (pat_lane),
    .lane_mask(lane_mask),
    .src      (src),
    .next_n   (next_n)
  );

  always_ff @(posedge clk) begin
    if (rst) lane_n <= '1;
    else     lane_n <= next_n;
  end

endmodule

// File: rtl/lane_sel_chk.sv
module lane_sel_chk #(
  parameter int LANES  = 2,
  parameter int PS_W   = 1,
  parameter int CNT_W  = 2,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_valid,
  input logic              access_start,
  input logic [PS_W-1:0]   port_size,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic              refresh,
  input logic [LANES-1:0]  pat_lane,
  input logic              bus_exc,
  input logic              hold_q,
  input logic [LANES-1:0]  lane_n
);

  assert_exc_blank_R9: assert property (@(posedge clk) disable iff (rst)
    bus_exc |=> (&lane_n));

  assert_hold_blank_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !access_start) |=> (&lane_n));

  assert_refresh_pattern_R8: assert property (@(posedge clk) disable iff (rst)
    (refresh && !bus_exc && !(hold_q && !access_start)) |=> (lane_n == ~$past(pat_lane)));

  assert_narrow_port_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && !refresh && port_size == '0) |=> (&lane_n[LANES-1:1]));

  assert_idle_blank_R7: assert property (@(posedge clk) disable iff (rst)
    (!refresh && (!cyc_valid || byte_cnt == '0)) |=> (&lane_n));

endmodule

bind lane_sel_gen lane_sel_chk #(
  .LANES(LANES), .PS_W(PS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_valid   (cyc_valid),
  .access_start(access_start),
  .port_size   (port_size),
  .byte_cnt    (byte_cnt),
  .refresh     (refresh),
  .pat_lane    (pat_lane),
  .bus_exc     (bus_exc),
  .hold_q      (hold_q),
  .lane_n      (lane_n)
);

// File: tb/tb_lane_sel_gen.sv
module tb_lane_sel_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_valid = 1'b0;
  logic       access_start = 1'b0;
  logic [0:0] port_size = '0;
  logic [1:0] byte_cnt = '0;
  logic [0:0] addr_lo = '0;
  logic       refresh = 1'b0;
  logic [1:0] pat_lane = '0;
  logic       bus_exc = 1'b0;
  logic [1:0] lane_n;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    m_hold = 1'b0;
  bit    done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_sel_gen dut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .access_start(access_start),
    .port_size(port_size), .byte_cnt(byte_cnt), .addr_lo(addr_lo),
    .refresh(refresh), .pat_lane(pat_lane), .bus_exc(bus_exc), .lane_n(lane_n)
  );

  // Expected strobe value, written from the requirements as a truth table.
  function automatic logic [1:0] model(bit r, bit v, bit st, bit ps, int cnt,
                                       bit a, bit rf, logic [1:0] pat, bit ex);
    bit blk;
    if (r) begin m_hold = 1'b0; return 2'b11; end
    blk = ex | (m_hold & ~st);
    m_hold = blk;
    if (blk)                 return 2'b11;
    if (rf)                  return ~pat;
    if (!v || cnt == 0)      return 2'b11;
    if (!ps)                 return 2'b10;
    if (a)                   return 2'b01;
    if (cnt == 1)            return 2'b10;
    return 2'b00;
  endfunction

  task automatic step(bit r, bit v, bit st, bit ps, int cnt, bit a,
                      bit rf, logic [1:0] pat, bit ex, string tag);
    item_t it;
    @(negedge clk);
    rst = r; cyc_valid = v; access_start = st; port_size = ps;
    byte_cnt = 2'(cnt); addr_lo = a; refresh = rf; pat_lane = pat; bus_exc = ex;
    it.exp = model(r, v, st, ps, cnt, a, rf, pat, ex);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: result of the item driven at a negedge appears after the next posedge.
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (lane_n !== it.exp) begin
        fails++;
        $display("FAIL %s: lane_n=%b expected %b", it.tag, lane_n, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    //    r  v  st ps cnt a  rf pat    ex
    step(1, 1, 0, 1, 2, 0, 1, 2'b11, 0, "R1 reset");
    step(1, 1, 0, 1, 2, 0, 0, 2'b00, 0, "R1 reset held");
    step(0, 0, 0, 1, 2, 0, 0, 2'b00, 0, "R7 idle after reset");
    step(0, 1, 1, 1, 2, 0, 0, 2'b00, 0, "R3 16-bit word even");
    step(0, 1, 0, 1, 3, 0, 0, 2'b00, 0, "R3 16-bit count 3 even");
    step(0, 1, 1, 1, 1, 0, 0, 2'b00, 0, "R4 byte even");
    step(0, 1, 1, 1, 1, 1, 0, 2'b00, 0, "R4 byte odd");
    step(0, 1, 1, 1, 2, 1, 0, 2'b00, 0, "R5 word odd clipped");
    step(0, 1, 1, 0, 1, 0, 0, 2'b00, 0, "R6 8-bit byte even");
    step(0, 1, 0, 0, 1, 1, 0, 2'b00, 0, "R6 8-bit byte odd");
    step(0, 1, 0, 0, 2, 1, 0, 2'b00, 0, "R6 8-bit word odd");
    step(0, 1, 0, 1, 0, 0, 0, 2'b00, 0, "R7 zero count");
    step(0, 0, 0, 1, 2, 0, 0, 2'b00, 0, "R7 no valid cycle");
    step(0, 1, 0, 1, 2, 0, 1, 2'b01, 0, "R8 refresh pattern 01");
    step(0, 0, 0, 0, 0, 1, 1, 2'b10, 0, "R8 refresh pattern 10");
    step(0, 1, 0, 0, 1, 0, 1, 2'b11, 0, "R8 refresh pattern 11");
    step(0, 0, 0, 1, 2, 0, 1, 2'b00, 0, "R8 refresh pattern 00");
    step(0, 1, 0, 1, 2, 0, 1, 2'b11, 1, "R9 exception during refresh");
    step(0, 1, 0, 1, 2, 0, 0, 2'b00, 0, "R10 hold same access");
    step(0, 1, 0, 1, 2, 0, 1, 2'b11, 0, "R10 hold over refresh");
    step(0, 1, 1, 1, 2, 0, 0, 2'b00, 1, "R10 start with exception");
    step(0, 1, 0, 1, 1, 1, 0, 2'b00, 0, "R10 still held");
    step(0, 1, 1, 1, 2, 0, 0, 2'b00, 0, "R10 new access releases");
    step(0, 1, 0, 1, 1, 1, 0, 2'b00, 0, "R2 decode after release");
    step(0, 1, 0, 1, 2, 0, 0, 2'b00, 1, "R9 exception normal cycle");
    step(1, 1, 0, 1, 2, 0, 0, 2'b00, 0, "R1 reset clears hold");
    step(0, 1, 0, 1, 2, 0, 0, 2'b00, 0, "R1 no hold after reset");
    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, "R7 final idle");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++; checks++;
      $display("FAIL R2: %0d results never observed, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule